// File: doc/BRIEF.md
# Disc Drive Command Responder

This block is the byte-wide register front end of a disc drive controller. A host writes parameter bytes and command bytes to it. For each command it recognises, the block loads a fixed sequence of reply bytes into a response queue. When the last byte is queued, it records an acknowledge cause code and raises an interrupt toward the processor. The host then reads the reply one byte at a time and clears the cause by writing ones to the flag register.

The block knows two commands. Command 0x01 is a status query. Command 0x19 is a test command that takes one parameter byte, and only subcommand 0x20 (the version report) is answered. Every other command byte is dropped without a trace. Only byte-sized accesses are legal. A wider access has no effect except a one-cycle error pulse.

Register map, selected by `addr`:
- Address 0: writing it issues a command, reading it pops one reply byte.
- Address 1: writing it queues a parameter byte.
- Address 2: reading it returns the cause in bits [2:0], writing it clears cause bits (write-one-to-clear).
- Address 3: reads as 0, and writes to it are ignored.

Top module: `disc_cmd_responder`

## Requirements
- R1: An access with `sizeWide` high raises `busError` for exactly the next cycle and has no other effect: a wide read returns 0 without popping, and a wide write issues no command and queues no parameter.
- R2: Command 0x19 consumes the head parameter byte. If that byte is 0x20, the bytes 0x99, 0x02, 0x01, 0xC3 are queued in that order.
- R3: Command 0x01 queues the single reply byte 0x02.
- R4: When the last byte of a reply is queued, the cause field (address 2, bits [2:0]) becomes 3. It reads as 3 within 8 cycles of the command write.
- R5: A byte write to address 2 clears exactly those cause bits that are 1 in bits [2:0] of the written data.
- R6: An unknown command byte produces no reply and no interrupt, and leaves the parameters untouched. Command 0x19 with any head byte other than 0x20, or with an empty parameter queue, also produces no reply and no interrupt, but still consumes the head byte when one is present.
- R7: The parameter queue holds 8 bytes and drops further writes while full. Commands consume parameters oldest first.
- R8: The reply queue holds 16 bytes. Reply bytes that arrive while it is full are dropped. Reading address 0 while the queue is empty returns 0.
- R9: `irqPulse` is high for one cycle, and only when the cause field goes from zero to non-zero. A reply that completes while the cause is already non-zero gives no pulse.
- R10: A command written while a previous reply is still being queued is ignored.
- R11: After reset the queues are empty, the cause is 0, and `rdData`, `busError` and `irqPulse` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| sizeWide | input | 1 | Access is wider than a byte (illegal) |
| addr | input | 2 | Register select |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data, registered one cycle after `rdEn` |
| busError | output | 1 | One-cycle pulse after an illegal wide access |
| irqPulse | output | 1 | One-cycle interrupt request to the processor |

## Verification
The assertions assume the host does not clear the cause in the same cycle a reply completes. They also assume `rdEn` and `wrEn` only carry meaning when they are high, so `addr`, `wrData` and `sizeWide` may be anything otherwise. The bench waits eight cycles after each command before it reads or clears anything, so every reply has finished queuing before the flag register is touched. It issues overlapping commands only in the dedicated busy test, where no clear is pending.

// File: rtl/disc_cmd_pkg.sv
package disc_cmd_pkg;

  localparam int DATA_W      = 8;
  localparam int CAUSE_W     = 3;
  localparam int PARAM_DEPTH = 8;
  localparam int RESP_DEPTH  = 16;
  localparam int MAX_RESP    = 4;
  localparam int IDX_W       = $clog2(MAX_RESP);

  localparam logic [DATA_W-1:0]  CMD_STATUS  = 8'h01;
  localparam logic [DATA_W-1:0]  CMD_TEST    = 8'h19;
  localparam logic [DATA_W-1:0]  SUB_VERSION = 8'h20;
  localparam logic [CAUSE_W-1:0] CAUSE_ACK   = 3'd3;

  localparam logic [1:0] ADDR_CMD   = 2'd0;
  localparam logic [1:0] ADDR_PARAM = 2'd1;
  localparam logic [1:0] ADDR_FLAG  = 2'd2;

  typedef enum logic { SEQ_STATUS = 1'b0, SEQ_VERSION = 1'b1 } seqSel_e;

  typedef struct packed {
    logic              paramPop;
    logic              respPush;
    logic [DATA_W-1:0] respByte;
    logic              causeSet;
  } ctlStrobe_t;

endpackage

// File: rtl/disc_byte_fifo.sv
module disc_byte_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] headData,
  output logic             empty
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] FULL_CNT = DEPTH[AW:0];

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wrPtr, rdPtr;
  logic [AW:0]      count;
  logic             full, doPush, doPop;

  assign full     = (count == FULL_CNT);
  assign empty    = (count == '0);
  assign doPush   = push && !full;
  assign doPop    = pop && !empty;
  assign headData = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= wrPtr + 1'b1;
      if (doPop)  rdPtr <= rdPtr + 1'b1;
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  AST_DROP_WHEN_FULL: assert property (@(posedge clk) disable iff (!rstN)
    (full && push && !pop) |=> (count == FULL_CNT)) else $error("fifo overflow"); // R8

  AST_EMPTY_POP_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (empty && pop && !push) |=> empty) else $error("pop from empty fifo"); // R8

endmodule

// File: rtl/disc_cmd_ctrl.sv
module disc_cmd_ctrl
  import disc_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdWrite,
  input  logic [DATA_W-1:0] cmdByte,
  input  logic [DATA_W-1:0] paramHead,
  input  logic              paramEmpty,
  output ctlStrobe_t        strobe
);
  typedef enum logic { ST_IDLE, ST_PUSH } state_e;

  state_e           state, stateNext;
  seqSel_e          seqSel, seqSelNext;
  logic [IDX_W-1:0] idx, idxNext, lastIdx;

  function automatic logic [DATA_W-1:0] replyByte(seqSel_e s, logic [IDX_W-1:0] i);
    if (s == SEQ_STATUS) return 8'h02;
    case (i)
      2'd0:    return 8'h99;
      2'd1:    return 8'h02;
      2'd2:    return 8'h01;
      default: return 8'hC3;
    endcase
  endfunction

  assign lastIdx = (seqSel == SEQ_STATUS) ? '0 : IDX_W'(MAX_RESP - 1);

  always_comb begin
    strobe     = '0;
    stateNext  = state;
    seqSelNext = seqSel;
    idxNext    = idx;
    case (state)
      ST_IDLE: begin
        if (cmdWrite) begin
          if (cmdByte == CMD_STATUS) begin
            stateNext  = ST_PUSH;
            seqSelNext = SEQ_STATUS;
            idxNext    = '0;
          end else if (cmdByte == CMD_TEST) begin
            strobe.paramPop = !paramEmpty;
            if (!paramEmpty && paramHead == SUB_VERSION) begin
              stateNext  = ST_PUSH;
              seqSelNext = SEQ_VERSION;
              idxNext    = '0;
            end
          end
        end
      end
      ST_PUSH: begin
        strobe.respPush = 1'b1;
        strobe.respByte = replyByte(seqSel, idx);
        if (idx == lastIdx) begin
          strobe.causeSet = 1'b1;
          stateNext       = ST_IDLE;
        end else begin
          idxNext = idx + 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      seqSel <= SEQ_STATUS;
      idx    <= '0;
    end else begin
      state  <= stateNext;
      seqSel <= seqSelNext;
      idx    <= idxNext;
    end
  end

  AST_CAUSE_WITH_LAST: assert property (@(posedge clk) disable iff (!rstN)
    strobe.causeSet |-> strobe.respPush) else $error("cause set without reply byte"); // R4

  AST_UNKNOWN_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && cmdWrite && cmdByte != CMD_STATUS && cmdByte != CMD_TEST)
    |=> (state == ST_IDLE)) else $error("unknown command started a reply"); // R6

  AST_BUSY_IGNORES_CMD: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PUSH && cmdWrite) |-> !strobe.paramPop) else $error("command accepted while busy"); // R10

  AST_VERSION_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && cmdWrite && cmdByte == CMD_TEST && !paramEmpty && paramHead == SUB_VERSION)
    |=> (strobe.respPush && strobe.respByte == 8'h99)) else $error("version reply order"); // R2

endmodule

// File: rtl/disc_cmd_datapath.sv
module disc_cmd_datapath
  import disc_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic              sizeWide,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wrData,
  input  ctlStrobe_t        strobe,
  output logic [DATA_W-1:0] paramHead,
  output logic              paramEmpty,
  output logic [DATA_W-1:0] rdData,
  output logic              busError,
  output logic              irqPulse
);
  logic [DATA_W-1:0]  respHead;
  logic               respEmpty;
  logic               paramWrite, respRead, flagWrite;
  logic [CAUSE_W-1:0] cause, causeNext;

  assign paramWrite = wrEn && !sizeWide && (addr == ADDR_PARAM);
  assign respRead   = rdEn && !sizeWide && (addr == ADDR_CMD);
  assign flagWrite  = wrEn && !sizeWide && (addr == ADDR_FLAG);

  disc_byte_fifo #(.WIDTH(DATA_W), .DEPTH(PARAM_DEPTH)) paramQ (
    .clk      (clk),
    .rstN     (rstN),
    .push     (paramWrite),
    .pushData (wrData),
    .pop      (strobe.paramPop),
    .headData (paramHead),
    .empty    (paramEmpty)
  );

  disc_byte_fifo #(.WIDTH(DATA_W), .DEPTH(RESP_DEPTH)) respQ (
    .clk      (clk),
    .rstN     (rstN),
    .push     (strobe.respPush),
    .pushData (strobe.respByte),
    .pop      (respRead),
    .headData (respHead),
    .empty    (respEmpty)
  );

  always_comb begin
    causeNext = cause;
    if (flagWrite) causeNext = cause & ~wrData[CAUSE_W-1:0];
    if (strobe.causeSet) causeNext = CAUSE_ACK;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cause    <= '0;
      irqPulse <= 1'b0;
      busError <= 1'b0;
      rdData   <= '0;
    end else begin
      cause    <= causeNext;
      irqPulse <= (cause == '0) && (causeNext != '0);
      busError <= (wrEn || rdEn) && sizeWide;
      if (rdEn) begin
        if (sizeWide) rdData <= '0;
        else begin
          case (addr)
            ADDR_CMD:  rdData <= respEmpty ? '0 : respHead;
            ADDR_FLAG: rdData <= {{(DATA_W-CAUSE_W){1'b0}}, cause};
            default:   rdData <= '0;
          endcase
        end
      end
    end
  end

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |=> !irqPulse) else $error("irq longer than one cycle"); // R9

  AST_IRQ_ON_RISE: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> (cause != '0 && $past(cause) == '0)) else $error("irq without cause rise"); // R9

  AST_WIDE_NO_POP: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && sizeWide && !respEmpty && !strobe.respPush) |=> $stable(respHead)) else $error("wide read popped"); // R1

  AST_CLEAR_W1C: assert property (@(posedge clk) disable iff (!rstN)
    (flagWrite && !strobe.causeSet) |=> ((cause & $past(wrData[CAUSE_W-1:0])) == '0)) else $error("w1c failed"); // R5

endmodule

// File: rtl/disc_cmd_responder.sv
module disc_cmd_responder
  import disc_cmd_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic        rdEn,
  input  logic        sizeWide,
  input  logic [1:0]  addr,
  input  logic [7:0]  wrData,
  output logic [7:0]  rdData,
  output logic        busError,
  output logic        irqPulse
);
  ctlStrobe_t        strobe;
  logic [DATA_W-1:0] paramHead;
  logic              paramEmpty;
  logic              cmdWrite;

  assign cmdWrite = wrEn && !sizeWide && (addr == ADDR_CMD);

  disc_cmd_ctrl ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .cmdWrite   (cmdWrite),
    .cmdByte    (wrData),
    .paramHead  (paramHead),
    .paramEmpty (paramEmpty),
    .strobe     (strobe)
  );

  disc_cmd_datapath dpath (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (wrEn),
    .rdEn       (rdEn),
    .sizeWide   (sizeWide),
    .addr       (addr),
    .wrData     (wrData),
    .strobe     (strobe),
    .paramHead  (paramHead),
    .paramEmpty (paramEmpty),
    .rdData     (rdData),
    .busError   (busError),
    .irqPulse   (irqPulse)
  );

  AST_WIDE_NO_CMD: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && sizeWide) |-> !strobe.paramPop) else $error("wide write acted"); // R1

endmodule

// File: tb/disc_cmd_responder_test.sv
module disc_cmd_responder_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0, rdEn = 1'b0, sizeWide = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic       busError, irqPulse;

  int checks = 0, errors = 0, irqCount = 0;
  logic finished = 1'b0;

  disc_cmd_responder uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .sizeWide(sizeWide),
    .addr(addr), .wrData(wrData), .rdData(rdData), .busError(busError), .irqPulse(irqPulse)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) if (rstN && irqPulse) irqCount++;

  typedef struct packed {
    logic [7:0]  cmd;
    logic        hasParam;
    logic [7:0]  param;
    logic [2:0]  len;
    logic [31:0] bytes;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{cmd: 8'h01, hasParam: 1'b0, param: 8'h00, len: 3'd1, bytes: 32'h02000000},
    '{cmd: 8'h19, hasParam: 1'b1, param: 8'h20, len: 3'd4, bytes: 32'h990201C3},
    '{cmd: 8'h19, hasParam: 1'b1, param: 8'h21, len: 3'd0, bytes: 32'h0},
    '{cmd: 8'h55, hasParam: 1'b0, param: 8'h00, len: 3'd0, bytes: 32'h0},
    '{cmd: 8'h19, hasParam: 1'b0, param: 8'h00, len: 3'd0, bytes: 32'h0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    @(negedge clk);
    v = rdData;
    rdEn = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int irqBefore;

    idle(3);
    rstN = 1'b1;
    idle(1);
    // R11 reset state
    chk("R11 rdData", rdData, 0);
    chk("R11 busError", busError, 0);
    chk("R11 irqPulse", irqPulse, 0);
    rdReg(2'd2, v); chk("R11 cause", v, 0);
    rdReg(2'd0, v); chk("R11 resp empty", v, 0);

    // vector table: R2 R3 R4 R6
    foreach (VECS[i]) begin
      irqBefore = irqCount;
      if (VECS[i].hasParam) wrReg(2'd1, VECS[i].param);
      wrReg(2'd0, VECS[i].cmd);
      idle(8);
      chk("R4 R9 irq count", irqCount - irqBefore, (VECS[i].len != 0) ? 1 : 0);
      rdReg(2'd2, v);
      chk("R4 cause", v, (VECS[i].len != 0) ? 3 : 0);
      for (int k = 0; k < VECS[i].len; k++) begin
        rdReg(2'd0, v);
        chk("R2 R3 reply byte", v, VECS[i].bytes[31 - 8*k -: 8]);
      end
      rdReg(2'd0, v); chk("R6 R8 nothing extra", v, 0);
      wrReg(2'd2, 8'h07);
    end

    // R5 partial write-one-to-clear, R9 no pulse on clear
    wrReg(2'd0, 8'h01); idle(6);
    rdReg(2'd0, v);
    irqBefore = irqCount;
    wrReg(2'd2, 8'h01); rdReg(2'd2, v); chk("R5 clear bit0", v, 2);
    wrReg(2'd2, 8'h04); rdReg(2'd2, v); chk("R5 clear unset bit", v, 2);
    wrReg(2'd2, 8'h02); rdReg(2'd2, v); chk("R5 clear bit1", v, 0);
    chk("R9 no irq on clear", irqCount - irqBefore, 0);

    // R1 wide accesses
    @(negedge clk); wrEn = 1'b1; sizeWide = 1'b1; addr = 2'd0; wrData = 8'h01;
    @(negedge clk); chk("R1 busError pulse", busError, 1); wrEn = 1'b0; sizeWide = 1'b0;
    @(negedge clk); chk("R1 busError ends", busError, 0);
    idle(6);
    rdReg(2'd2, v); chk("R1 wide write no cmd", v, 0);
    wrReg(2'd0, 8'h01); idle(6);
    @(negedge clk); rdEn = 1'b1; sizeWide = 1'b1; addr = 2'd0;
    @(negedge clk); chk("R1 wide read zero", rdData, 0); chk("R1 wide read err", busError, 1);
    rdEn = 1'b0; sizeWide = 1'b0;
    rdReg(2'd0, v); chk("R1 wide read no pop", v, 8'h02);
    wrReg(2'd2, 8'h07);

    // R10 command during reply
    irqBefore = irqCount;
    @(negedge clk); wrEn = 1'b1; addr = 2'd0; wrData = 8'h01;
    @(negedge clk);
    @(negedge clk); wrEn = 1'b0;
    idle(6);
    rdReg(2'd0, v); chk("R10 first reply", v, 8'h02);
    rdReg(2'd0, v); chk("R10 second ignored", v, 0);
    chk("R10 single irq", irqCount - irqBefore, 1);
    wrReg(2'd2, 8'h07);

    // R7 parameter overflow and order
    irqBefore = irqCount;
    for (int k = 0; k < 8; k++) wrReg(2'd1, 8'h00);
    wrReg(2'd1, 8'h20);
    for (int k = 0; k < 9; k++) begin wrReg(2'd0, 8'h19); idle(6); end
    rdReg(2'd0, v); chk("R7 ninth param dropped", v, 0);
    chk("R7 no irq", irqCount - irqBefore, 0);
    wrReg(2'd1, 8'h21); wrReg(2'd1, 8'h20);
    wrReg(2'd0, 8'h19); idle(6);
    rdReg(2'd0, v); chk("R7 oldest first", v, 0);
    wrReg(2'd0, 8'h19); idle(8);
    rdReg(2'd0, v); chk("R7 second param", v, 8'h99);
    for (int k = 0; k < 3; k++) rdReg(2'd0, v);
    wrReg(2'd2, 8'h07);

    // R8 reply overflow, R9 no pulse while cause set
    irqBefore = irqCount;
    for (int k = 0; k < 4; k++) wrReg(2'd1, 8'h20);
    for (int k = 0; k < 4; k++) begin wrReg(2'd0, 8'h19); idle(8); end
    wrReg(2'd0, 8'h01); idle(6);
    chk("R9 one irq while set", irqCount - irqBefore, 1);
    for (int k = 0; k < 16; k++) begin
      rdReg(2'd0, v);
      chk("R8 full queue byte", v, (k % 4 == 0) ? 8'h99 : (k % 4 == 1) ? 8'h02 : (k % 4 == 2) ? 8'h01 : 8'hC3);
    end
    rdReg(2'd0, v); chk("R8 overflow dropped", v, 0);
    wrReg(2'd2, 8'h07);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule